// File: doc/BRIEF.md
# Multi-Mode Pin Counter with Shared Phase Accumulator

The block is one counter slice of a processor core. A single phase accumulator serves two jobs, selected by a mode field. In duty mode the accumulator works as a numerically controlled oscillator. The frequency register is added on every clock, and the carry out of the top bit drives a one-clock pulse on the first selected pin. In logic-AND mode the same accumulator becomes an event counter. It adds the frequency register on every clock where both selected pins of the synchronised input bus are high. A third mode switches the counter off.

Software programs the block through a small write port with three targets: control, frequency and phase. The control word holds the mode and two pin selectors. A write to the phase target loads the accumulator directly, and takes precedence over that clock's accumulate step. Pin inputs pass through a multi-flop synchroniser before any condition is evaluated. The logic condition never looks at the counter's own drive signal. It therefore gives the same count whichever input carries the pulse and whichever carries the steady level. The accumulator is visible on a read-only output.

Top module: `pin_event_counter`

## Requirements
- R1: While reset is asserted and after it is released, the accumulator, the control word and the frequency register are zero. pin_out and pin_oe are all zero.
- R2: A write with wr_en high loads a register at the next rising edge. wr_sel 0 selects control, 1 selects frequency and 2 selects phase; value 3 is ignored. The control word has pin A select in bits [4:0], pin B select in bits [9:5] and the mode in bits [14:10].
- R3: Mode 5'b00000, and any code other than the two active ones, leaves the accumulator unchanged. In these modes pin_oe and pin_out are all zero.
- R4: Mode 5'b00110 adds the frequency register to the accumulator on every clock. The carry out of the top bit of that add appears on pin_out[A] for the following cycle. pin_oe has exactly bit A set.
- R5: In duty mode, starting from phase 0, a frequency of 32'h2000_0000 gives one-clock pulses on pin A exactly 8 clocks apart.
- R6: Mode 5'b11000 adds the frequency register only on clocks where synchronised pin_in[A] and pin_in[B] are both high. In this mode pin_oe and pin_out stay zero.
- R7: In AND mode, swapping which selected pin carries a pulse train and which carries a steady high level gives the same accumulated count.
- R8: A level applied on pin_in first affects the accumulator at the third rising edge after it is applied (two synchroniser flops).
- R9: A phase write loads wr_data into the accumulator in place of that clock's accumulate step, and pin_out is zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 frequency, 2 phase |
| wr_data | input | 32 | Write data |
| pin_in | input | 32 | Asynchronous pin input bus |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables |
| acc_value | output | 32 | Current accumulator value |

## Verification
Every cycle, the assertions check how the accumulator moves in each mode. In off and unsupported modes it must hold. In duty mode it must grow by the frequency value. In AND mode it must step only when both synchronised pins are high. A phase write must load the accumulator and override the step. The assertions also check that drive appears only on the enabled pin A, and only in duty mode. Three properties only the bench scenarios can show. The first is that pulses come out eight clocks apart at the right frequency value. The second is that the synchroniser adds exactly two clocks from a pin change to a count. The third is that swapping pulse and steady level between the two selected pins gives the same count.

// File: rtl/pec_pkg.sv
package pec_pkg;
   localparam int MODE_W = 5;
   localparam logic [MODE_W-1:0] MODE_OFF  = 5'b00000;
   localparam logic [MODE_W-1:0] MODE_DUTY = 5'b00110;
   localparam logic [MODE_W-1:0] MODE_AND  = 5'b11000;

   localparam int WSEL_W = 2;
   localparam logic [WSEL_W-1:0] WSEL_CTRL  = 2'd0;
   localparam logic [WSEL_W-1:0] WSEL_FREQ  = 2'd1;
   localparam logic [WSEL_W-1:0] WSEL_PHASE = 2'd2;
endpackage

// File: rtl/pec_sync.sv
module pec_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pec_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain <= {chain[STAGES-2:0], d};
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pec_regs.sv
module pec_regs
   import pec_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WSEL_W-1:0] wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [MODE_W-1:0] mode,
   output logic [SEL_W-1:0]  sel_a,
   output logic [SEL_W-1:0]  sel_b,
   output logic [DATA_W-1:0] freq
);
   localparam int CTRL_W = 2*SEL_W + MODE_W;

   if (DATA_W < CTRL_W) begin : g_bad_width
      $error("pec_regs: DATA_W too narrow for the control word");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [DATA_W-1:0] freq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         freq_q <= '0;
      end else if (wr_en) begin
         if (wr_sel == WSEL_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
         if (wr_sel == WSEL_FREQ) freq_q <= wr_data;
      end
   end

   assign sel_a = ctrl_q[SEL_W-1:0];
   assign sel_b = ctrl_q[2*SEL_W-1:SEL_W];
   assign mode  = ctrl_q[CTRL_W-1:2*SEL_W];
   assign freq  = freq_q;
endmodule

// File: rtl/pec_accum.sv
module pec_accum #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             load_en,
   input  logic [ACC_W-1:0] load_val,
   input  logic [ACC_W-1:0] addend,
   output logic [ACC_W-1:0] acc,
   output logic             carry
);
   localparam int SUM_W = ACC_W + 1;

   logic [SUM_W-1:0] sum;
   logic [ACC_W-1:0] acc_q;
   logic             carry_q;

   assign sum = {1'b0, acc_q} + {1'b0, addend};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         carry_q <= 1'b0;
      end else if (load_en) begin
         acc_q   <= load_val;
         carry_q <= 1'b0;
      end else if (step_en) begin
         acc_q   <= sum[ACC_W-1:0];
         carry_q <= sum[ACC_W];
      end else begin
         carry_q <= 1'b0;
      end
   end

   assign acc   = acc_q;
   assign carry = carry_q;
endmodule

// File: rtl/pec_pindrive.sv
module pec_pindrive #(
   parameter int PIN_COUNT = 32,
   parameter int SEL_W     = 5
) (
   input  logic                 drive_en,
   input  logic [SEL_W-1:0]     sel,
   input  logic                 level,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe
);
   for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
      assign pin_oe[p]  = drive_en && (sel == SEL_W'(p));
      assign pin_out[p] = pin_oe[p] && level;
   end
endmodule

// File: rtl/pin_event_counter.sv
module pin_event_counter
   import pec_pkg::*;
#(
   parameter int ACC_W       = 32,
   parameter int PIN_COUNT   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_sel,
   input  logic [ACC_W-1:0]     wr_data,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe,
   output logic [ACC_W-1:0]     acc_value
);
   localparam int SEL_W = $clog2(PIN_COUNT);

   if (PIN_COUNT < 2 || (1 << SEL_W) != PIN_COUNT) begin : g_bad_pins
      $error("pin_event_counter: PIN_COUNT must be a power of two");
   end
   if (ACC_W < 2*SEL_W + MODE_W) begin : g_bad_acc
      $error("pin_event_counter: ACC_W too narrow");
   end

   logic [MODE_W-1:0]    mode_q;
   logic [SEL_W-1:0]     sel_a_q;
   logic [SEL_W-1:0]     sel_b_q;
   logic [ACC_W-1:0]     freq_q;
   logic [PIN_COUNT-1:0] pin_sync;
   logic                 carry_q;
   logic                 phase_wr;
   logic                 duty_on;
   logic                 and_hit;
   logic                 step_en;

   pec_regs #(.DATA_W(ACC_W), .SEL_W(SEL_W)) regs_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .mode    (mode_q),
      .sel_a   (sel_a_q),
      .sel_b   (sel_b_q),
      .freq    (freq_q)
   );

   pec_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   assign phase_wr = wr_en && (wr_sel == WSEL_PHASE);
   assign duty_on  = (mode_q == MODE_DUTY);
   assign and_hit  = (mode_q == MODE_AND) && pin_sync[sel_a_q] && pin_sync[sel_b_q];
   assign step_en  = duty_on || and_hit;

   pec_accum #(.ACC_W(ACC_W)) accum_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_en  (step_en),
      .load_en  (phase_wr),
      .load_val (wr_data),
      .addend   (freq_q),
      .acc      (acc_value),
      .carry    (carry_q)
   );

   pec_pindrive #(.PIN_COUNT(PIN_COUNT), .SEL_W(SEL_W)) drive_i (
      .drive_en (duty_on),
      .sel      (sel_a_q),
      .level    (carry_q),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );
endmodule

// File: rtl/pec_checker.sv
module pec_checker
   import pec_pkg::*;
#(
   parameter int ACC_W     = 32,
   parameter int PIN_COUNT = 32,
   parameter int SEL_W     = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic [1:0]           wr_sel,
   input logic [ACC_W-1:0]     wr_data,
   input logic [MODE_W-1:0]    mode,
   input logic [SEL_W-1:0]     sel_a,
   input logic [SEL_W-1:0]     sel_b,
   input logic [ACC_W-1:0]     freq,
   input logic [PIN_COUNT-1:0] pin_sync,
   input logic [PIN_COUNT-1:0] pin_out,
   input logic [PIN_COUNT-1:0] pin_oe,
   input logic [ACC_W-1:0]     acc_value
);
   logic ld;
   logic idle_mode;
   logic both_hi;
   assign ld        = wr_en && (wr_sel == WSEL_PHASE);
   assign idle_mode = (mode != MODE_DUTY) && (mode != MODE_AND);
   assign both_hi   = pin_sync[sel_a] && pin_sync[sel_b];

   assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_mode && !ld) |=> (acc_value == $past(acc_value)));

   assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_DUTY) |-> (pin_oe == '0 && pin_out == '0));

   assert_duty_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DUTY) |-> (pin_oe == (PIN_COUNT'(1) << sel_a)));

   assert_out_in_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_out & ~pin_oe) == '0));

   assert_duty_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DUTY && !ld) |=> (acc_value == $past(acc_value) + $past(freq)));

   assert_and_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_AND && !ld && !both_hi) |=> (acc_value == $past(acc_value)));

   assert_and_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_AND && !ld && both_hi) |=> (acc_value == $past(acc_value) + $past(freq)));

   assert_phase_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (acc_value == $past(wr_data) && pin_out == '0));
endmodule

bind pin_event_counter pec_checker #(
   .ACC_W     (ACC_W),
   .PIN_COUNT (PIN_COUNT),
   .SEL_W     (SEL_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .mode      (mode_q),
   .sel_a     (sel_a_q),
   .sel_b     (sel_b_q),
   .freq      (freq_q),
   .pin_sync  (pin_sync),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .acc_value (acc_value)
);

// File: tb/pin_event_counter_tb_top.sv
module pin_event_counter_tb_top;
   localparam logic [4:0] M_OFF  = 5'b00000;
   localparam logic [4:0] M_DUTY = 5'b00110;
   localparam logic [4:0] M_AND  = 5'b11000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out;
   logic [31:0] pin_oe;
   logic [31:0] acc_value;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   bit auto_chk = 0;

   always #10 clk = ~clk;

   pin_event_counter dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .acc_value(acc_value)
   );

   // reference model built from the requirements
   logic [4:0]  m_mode, m_a, m_b;
   logic [31:0] m_freq, m_acc, m_s1, m_s2;
   logic        m_carry;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = '0; m_a = '0; m_b = '0; m_freq = '0; m_acc = '0;
         m_s1 = '0; m_s2 = '0; m_carry = 1'b0;
      end else begin
         logic        hit;
         logic [32:0] s;
         hit = (m_mode == M_DUTY) || (m_mode == M_AND && m_s2[m_a] && m_s2[m_b]);
         s = {1'b0, m_acc} + {1'b0, m_freq};
         if (wr_en && wr_sel == 2'd2) begin
            m_acc = wr_data; m_carry = 1'b0;
         end else if (hit) begin
            m_acc = s[31:0]; m_carry = s[32];
         end else begin
            m_carry = 1'b0;
         end
         if (wr_en && wr_sel == 2'd0) begin
            m_a = wr_data[4:0]; m_b = wr_data[9:5]; m_mode = wr_data[14:10];
         end
         if (wr_en && wr_sel == 2'd1) m_freq = wr_data;
         m_s2 = m_s1;
         m_s1 = pin_in;
      end
   end

   function automatic logic [31:0] exp_oe(logic [4:0] mode, logic [4:0] a);
      return (mode == M_DUTY) ? (32'd1 << a) : 32'd0;
   endfunction

   function automatic logic [31:0] ctrl_word(logic [4:0] mode, logic [4:0] a, logic [4:0] b);
      return {17'd0, mode, b, a};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_cmp();
      string tag;
      tag = (m_mode == M_DUTY) ? "R4" : (m_mode == M_AND) ? "R6" : "R3";
      chk({tag, " acc"}, acc_value, m_acc);
      chk({tag, " oe"}, pin_oe, exp_oe(m_mode, m_a));
      chk({tag, " out"}, pin_out, (m_mode == M_DUTY && m_carry) ? (32'd1 << m_a) : 32'd0);
   endtask

   always @(negedge clk) if (rst_n && auto_chk && !done) model_cmp();

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(logic [1:0] sel, logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      int delta1, delta2, pulses, last, gap_bad;
      logic [31:0] base;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 acc", acc_value, 32'd0);
      chk("R1 oe", pin_oe, 32'd0);
      chk("R1 out", pin_out, 32'd0);
      rst_n = 1'b1;
      tick();
      chk("R1 acc after release", acc_value, 32'd0);
      auto_chk = 1;

      // R5: duty pulses every 8 clocks on pin A = 5
      wr(2'd1, 32'h2000_0000);
      wr(2'd2, 32'd0);
      wr(2'd0, ctrl_word(M_DUTY, 5'd5, 5'd0));
      pulses = 0; last = -1; gap_bad = 0;
      for (int c = 0; c < 64; c++) begin
         tick();
         if (pin_out[5]) begin
            if (last >= 0 && c - last != 8) gap_bad++;
            pulses++; last = c;
         end
      end
      chk("R5 pulse count", pulses, 8);
      chk("R5 pulse gap", gap_bad, 0);
      chk("R4 oe only pin A", pin_oe, 32'h0000_0020);

      // R9: phase write overrides step
      wr(2'd1, 32'd5);
      wr(2'd2, 32'h0000_1234);
      chk("R9 phase load", acc_value, 32'h0000_1234);
      chk("R9 no pulse", pin_out, 32'd0);
      tick();
      chk("R4 step after load", acc_value, 32'h0000_1239);

      // R3: off mode holds, unsupported code holds
      pin_in = '1;
      wr(2'd0, ctrl_word(M_OFF, 5'd1, 5'd2));
      base = acc_value;
      repeat (6) tick();
      chk("R3 off hold", acc_value, base);
      chk("R3 off oe", pin_oe, 32'd0);
      wr(2'd0, ctrl_word(5'b00101, 5'd1, 5'd2));
      repeat (6) tick();
      chk("R3 unsupported hold", acc_value, base);
      wr(2'd3, 32'hFFFF_FFFF);
      chk("R2 sel3 ignored", acc_value, base);

      // R8: synchroniser latency
      pin_in = '0;
      wr(2'd1, 32'd1);
      wr(2'd0, ctrl_word(M_AND, 5'd3, 5'd7));
      repeat (3) tick();
      wr(2'd2, 32'd0);
      pin_in[3] = 1'b1; pin_in[7] = 1'b1;
      tick(); chk("R8 edge1", acc_value, 32'd0);
      tick(); chk("R8 edge2", acc_value, 32'd0);
      tick(); chk("R8 edge3", acc_value, 32'd1);
      chk("R6 oe off", pin_oe, 32'd0);

      // R7: swap pulse and steady level
      pin_in = '0;
      repeat (3) tick();
      wr(2'd2, 32'd0);
      for (int c = 0; c < 80; c++) begin
         pin_in[7] = 1'b1; pin_in[3] = (c % 8 == 0);
         tick();
      end
      pin_in = '0; repeat (3) tick();
      delta1 = acc_value;
      wr(2'd2, 32'd0);
      for (int c = 0; c < 80; c++) begin
         pin_in[3] = 1'b1; pin_in[7] = (c % 8 == 0);
         tick();
      end
      pin_in = '0; repeat (3) tick();
      delta2 = acc_value;
      chk("R7 pulse on B", delta1, 10);
      chk("R7 pulse on A", delta2, 10);
      chk("R7 symmetric", delta1, delta2);

      // R2: random register traffic and pin activity against the model
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom_range(0, 19);
         pin_in = ($urandom_range(0, 1) == 1) ? 32'hFFFF_FFFF : $urandom();
         if (r == 0) begin
            int m;
            logic [4:0] md;
            m = $urandom_range(0, 3);
            md = (m == 0) ? M_OFF : (m == 1) ? M_DUTY : (m == 2) ? M_AND : 5'($urandom());
            wr(2'd0, ctrl_word(md, 5'($urandom()), 5'($urandom())));
         end else if (r == 1) begin
            wr(2'd1, $urandom());
         end else if (r == 2) begin
            wr(2'($urandom_range(2, 3)), $urandom());
         end else begin
            tick();
         end
      end
      chk("R2 final acc", acc_value, m_acc);
      finish_run();
   end
endmodule